// File: doc/BRIEF.md
# Helper Thread Spawn Controller

This controller sits beside the cores of a four-core chip multiprocessor that runs speculative threads in a strict total order. When a core reports a second-level cache miss, the controller decides whether to copy the thread on that core into a runahead helper on an idle core. The helper runs ahead to warm caches and predictors, and it is discarded when it has nothing left to do. The controller also removes the helper as soon as the helper no longer serves its purpose.

A small table of 2-bit saturating counters, indexed by address bits of the missing load, tracks whether a predicted load value has recently been correct. A miss leads to a spawn only when this counter is saturated. The miss must also come from the thread that is currently the most speculative, and no helper may already exist. The block issues registered spawn and kill pulses that carry core indices. It also drives one squash-suppress line per core, which keeps the helper's core out of dependence-violation squashes and stops it from causing any.

Top module: `helper_spawn_ctrl`

## Requirements
- R1: After reset, spawn_o, kill_o and every squash_sup_o bit are 0, and all confidence counters are 0, so no miss can spawn until the table has been trained.
- R2: The table has one 2-bit counter per value of miss address bits [7:2]. train_valid_i with train_ok_i=1 increments the counter and saturates at 3. train_valid_i with train_ok_i=0 clears it to 0. A miss counts as confident only when its counter is 3, and a lookup in the same cycle as an update reads the value before the update.
- R3: A spawn is granted only if all of these hold: miss_valid_i is 1, the miss is confident, miss_core_i is the most speculative core, no helper is alive, and at least one core is idle. The most speculative core is the busy core with the largest rank (ties go to the lower index), and the helper's core is never counted. A core is idle when its core_busy_i bit is 0 and it is not the helper's core.
- R4: A granted spawn raises spawn_o for exactly the one cycle after the miss is presented. In that cycle spawn_src_o is the missing core and spawn_dst_o is the lowest-numbered idle core. Both fields are 0 when spawn_o is 0.
- R5: At most one helper exists. A miss presented while a helper is alive is ignored.
- R6: The helper is killed when its parent is no longer the most speculative core. This happens, for example, when a busy core with a larger rank appears, or when the parent goes idle.
- R7: The helper is killed when core_done_i is set for either its parent or its own core, or when core_exc_i is set for its own core.
- R8: kill_o is a one-cycle pulse in the cycle after the kill condition, with kill_core_o equal to the helper core (0 when kill_o is 0). The helper's core counts as idle from that cycle on.
- R9: squash_sup_o has exactly one bit set, the helper core's bit, from the cycle in which spawn_o is high through the cycle before kill_o. It is all zeros otherwise, including the kill_o cycle.
- R10: When a kill condition and a spawn request fall in the same cycle, the kill is issued and the request is dropped. A qualifying miss presented during the kill_o cycle is granted, with spawn_o in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| core_busy_i | input | 4 | Core holds an ordered speculative thread |
| core_rank_i | input | 12 | 3-bit order rank per core (core c at [3c+2:3c]), larger is more speculative |
| core_done_i | input | 4 | Thread on core finished this cycle |
| core_exc_i | input | 4 | Thread on core raised an exception this cycle |
| miss_valid_i | input | 1 | Second-level miss event |
| miss_core_i | input | 2 | Core that missed |
| miss_addr_i | input | 32 | Load address of the miss |
| train_valid_i | input | 1 | Value prediction outcome available |
| train_addr_i | input | 32 | Load address of the outcome |
| train_ok_i | input | 1 | 1 if the predicted value was correct |
| spawn_o | output | 1 | Clone command pulse |
| spawn_src_o | output | 2 | Parent core to clone |
| spawn_dst_o | output | 2 | Idle core receiving the helper |
| kill_o | output | 1 | Helper teardown pulse |
| kill_core_o | output | 2 | Core of the helper being killed |
| squash_sup_o | output | 4 | Per-core squash suppress (helper core only) |

## Verification
Killing the helper and accepting a new spawn request are the two functions that meet in one cycle. The bench provokes this by making a newer busy core the most speculative while that same core presents a confident miss. It expects kill_o with no spawn on the next cycle, and then a spawn one cycle later when the miss is presented again during the kill pulse. Random phases change busy sets, ranks, completion and exception flags while misses and training run. In those phases a reference model checks every cycle that spawn_o and kill_o never coincide and that the freed core is handed out again at once.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
  localparam int unsigned CONF_W = 2;
  typedef logic [CONF_W-1:0] conf_t;
  localparam conf_t CONF_MAX = '1;

  function automatic conf_t conf_next(conf_t cur, logic ok);
    if (!ok) return '0;
    if (cur == CONF_MAX) return cur;
    return cur + conf_t'(1);
  endfunction
endpackage

// File: rtl/hsc_conf_table.sv
module hsc_conf_table
  import hsc_pkg::*;
#(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned IDX_LSB = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_addr_i,
  input  logic              upd_ok_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic              lk_hit_o
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  conf_t            cnt_q [ENTRIES];
  logic [IDX_W-1:0] upd_idx, lk_idx;

  assign upd_idx = upd_addr_i[IDX_LSB +: IDX_W];
  assign lk_idx  = lk_addr_i[IDX_LSB +: IDX_W];

  logic unused_addr_bits;
  assign unused_addr_bits = ^{upd_addr_i[ADDR_W-1:IDX_LSB+IDX_W], upd_addr_i[IDX_LSB-1:0],
                              lk_addr_i[ADDR_W-1:IDX_LSB+IDX_W], lk_addr_i[IDX_LSB-1:0]};

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q[e] <= '0;
      else if (upd_valid_i && upd_idx == IDX_W'(e)) cnt_q[e] <= conf_next(cnt_q[e], upd_ok_i);
    end
  end

  // lookup sees pre-update value
  assign lk_hit_o = (cnt_q[lk_idx] == CONF_MAX);

  // R2
  conf_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !upd_ok_i) |=> (cnt_q[$past(upd_idx)] == '0));
  // R2
  conf_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_ok_i && cnt_q[upd_idx] == CONF_MAX) |=> (cnt_q[$past(upd_idx)] == CONF_MAX));
endmodule

// File: rtl/hsc_spec_order.sv
module hsc_spec_order #(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned RANK_W    = 3,
  localparam int unsigned CORE_W   = $clog2(NUM_CORES)
) (
  input  logic [NUM_CORES-1:0]        busy_i,
  input  logic [NUM_CORES*RANK_W-1:0] rank_i,
  input  logic [NUM_CORES-1:0]        excl_i,
  output logic                        top_vld_o,
  output logic [CORE_W-1:0]           top_idx_o
);
  logic [RANK_W-1:0] best;

  always_comb begin
    top_vld_o = 1'b0;
    top_idx_o = '0;
    best      = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (busy_i[c] && !excl_i[c]) begin
        // strict compare keeps lower index on ties
        if (!top_vld_o || rank_i[c*RANK_W +: RANK_W] > best) begin
          top_vld_o = 1'b1;
          top_idx_o = CORE_W'(c);
          best      = rank_i[c*RANK_W +: RANK_W];
        end
      end
    end
  end
endmodule

// File: rtl/hsc_free_pick.sv
module hsc_free_pick #(
  parameter int unsigned NUM_CORES = 4,
  localparam int unsigned CORE_W   = $clog2(NUM_CORES)
) (
  input  logic [NUM_CORES-1:0] free_i,
  output logic                 any_o,
  output logic [CORE_W-1:0]    idx_o
);
  always_comb begin
    any_o = |free_i;
    idx_o = '0;
    for (int c = NUM_CORES - 1; c >= 0; c--) begin
      if (free_i[c]) idx_o = CORE_W'(c);
    end
  end
endmodule

// File: rtl/helper_spawn_ctrl.sv
module helper_spawn_ctrl #(
  parameter int unsigned NUM_CORES    = 4,
  parameter int unsigned RANK_W       = 3,
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned CONF_ENTRIES = 64,
  parameter int unsigned CONF_IDX_LSB = 2,
  localparam int unsigned CORE_W      = $clog2(NUM_CORES)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_CORES-1:0]        core_busy_i,
  input  logic [NUM_CORES*RANK_W-1:0] core_rank_i,
  input  logic [NUM_CORES-1:0]        core_done_i,
  input  logic [NUM_CORES-1:0]        core_exc_i,
  input  logic                        miss_valid_i,
  input  logic [CORE_W-1:0]           miss_core_i,
  input  logic [ADDR_W-1:0]           miss_addr_i,
  input  logic                        train_valid_i,
  input  logic [ADDR_W-1:0]           train_addr_i,
  input  logic                        train_ok_i,
  output logic                        spawn_o,
  output logic [CORE_W-1:0]           spawn_src_o,
  output logic [CORE_W-1:0]           spawn_dst_o,
  output logic                        kill_o,
  output logic [CORE_W-1:0]           kill_core_o,
  output logic [NUM_CORES-1:0]        squash_sup_o
);
  logic              hlp_vld_q;
  logic [CORE_W-1:0] hlp_core_q, par_core_q;

  logic [NUM_CORES-1:0] hlp_mask, free_vec;
  logic                 top_vld, free_any, conf_hit;
  logic [CORE_W-1:0]    top_idx, free_idx;
  logic                 parent_lost, kill_cond, spawn_req, spawn_go;

  assign hlp_mask = hlp_vld_q ? (NUM_CORES'(1) << hlp_core_q) : '0;
  assign free_vec = ~core_busy_i & ~hlp_mask;

  hsc_conf_table #(
    .ENTRIES (CONF_ENTRIES),
    .ADDR_W  (ADDR_W),
    .IDX_LSB (CONF_IDX_LSB)
  ) u_conf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .upd_valid_i (train_valid_i),
    .upd_addr_i  (train_addr_i),
    .upd_ok_i    (train_ok_i),
    .lk_addr_i   (miss_addr_i),
    .lk_hit_o    (conf_hit)
  );

  hsc_spec_order #(
    .NUM_CORES (NUM_CORES),
    .RANK_W    (RANK_W)
  ) u_order (
    .busy_i    (core_busy_i),
    .rank_i    (core_rank_i),
    .excl_i    (hlp_mask),
    .top_vld_o (top_vld),
    .top_idx_o (top_idx)
  );

  hsc_free_pick #(
    .NUM_CORES (NUM_CORES)
  ) u_free (
    .free_i (free_vec),
    .any_o  (free_any),
    .idx_o  (free_idx)
  );

  assign parent_lost = !top_vld || (top_idx != par_core_q);
  assign kill_cond   = hlp_vld_q && (parent_lost || core_done_i[par_core_q] ||
                                     core_done_i[hlp_core_q] || core_exc_i[hlp_core_q]);
  assign spawn_req   = miss_valid_i && conf_hit && top_vld && (miss_core_i == top_idx);
  // kill wins; live helper blocks any spawn
  assign spawn_go    = spawn_req && !hlp_vld_q && !kill_cond && free_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hlp_vld_q   <= 1'b0;
      hlp_core_q  <= '0;
      par_core_q  <= '0;
      spawn_o     <= 1'b0;
      spawn_src_o <= '0;
      spawn_dst_o <= '0;
      kill_o      <= 1'b0;
      kill_core_o <= '0;
    end else begin
      spawn_o     <= spawn_go;
      spawn_src_o <= spawn_go ? miss_core_i : '0;
      spawn_dst_o <= spawn_go ? free_idx : '0;
      kill_o      <= kill_cond;
      kill_core_o <= kill_cond ? hlp_core_q : '0;
      if (spawn_go) begin
        hlp_vld_q  <= 1'b1;
        hlp_core_q <= free_idx;
        par_core_q <= miss_core_i;
      end else if (kill_cond) begin
        hlp_vld_q  <= 1'b0;
      end
    end
  end

  assign squash_sup_o = hlp_mask;

  // R9
  sup_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(squash_sup_o));
  // R8
  kill_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_o |=> !kill_o);
  // R8
  kill_had_helper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_o |-> ($past(squash_sup_o) != '0));
  // R5
  single_helper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spawn_o |=> !spawn_o);
  // R10
  spawn_kill_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(spawn_o && kill_o));
  // R4
  spawn_from_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spawn_o |-> $past(miss_valid_i));
  // R9
  sup_on_spawn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spawn_o |-> ($countones(squash_sup_o) == 1));
endmodule

// File: tb/tb_helper_spawn_ctrl.sv
module tb_helper_spawn_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  busy = '0, done = '0, exc = '0;
  logic [11:0] rank = '0;
  logic        mv = 1'b0, tv = 1'b0, tok = 1'b0;
  logic [1:0]  mcore = '0;
  logic [31:0] maddr = '0, taddr = '0;
  logic        spawn, kill;
  logic [1:0]  src, dst, kcore;
  logic [3:0]  sup;

  int n_chk = 0, n_bad = 0;
  int m_conf [64];
  bit m_hv = 0;
  int m_hc = 0, m_pc = 0;

  always #5 clk = ~clk;

  helper_spawn_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .core_busy_i(busy), .core_rank_i(rank),
    .core_done_i(done), .core_exc_i(exc), .miss_valid_i(mv), .miss_core_i(mcore),
    .miss_addr_i(maddr), .train_valid_i(tv), .train_addr_i(taddr), .train_ok_i(tok),
    .spawn_o(spawn), .spawn_src_o(src), .spawn_dst_o(dst), .kill_o(kill),
    .kill_core_o(kcore), .squash_sup_o(sup)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // one cycle: inputs already set; model, clock edge, compare
  task automatic cyc();
    int mi = -1, best = -1, fi = -1;
    bit kc, sg, hit;
    int e_src, e_dst, e_kc, e_sup;
    for (int c = 0; c < 4; c++)
      if (busy[c] && !(m_hv && m_hc == c))
        if (mi < 0 || int'(rank[c*3 +: 3]) > best) begin mi = c; best = int'(rank[c*3 +: 3]); end
    for (int c = 3; c >= 0; c--)
      if (!busy[c] && !(m_hv && m_hc == c)) fi = c;
    kc  = m_hv && (mi < 0 || mi != m_pc || done[m_pc] || done[m_hc] || exc[m_hc]);
    hit = (m_conf[maddr[7:2]] == 3);
    sg  = mv && hit && mi >= 0 && int'(mcore) == mi && !m_hv && fi >= 0;
    e_src = sg ? int'(mcore) : 0;
    e_dst = sg ? fi : 0;
    e_kc  = kc ? m_hc : 0;
    if (sg) begin m_hv = 1; m_hc = fi; m_pc = int'(mcore); end
    else if (kc) m_hv = 0;
    if (tv) m_conf[taddr[7:2]] = tok ? ((m_conf[taddr[7:2]] == 3) ? 3 : m_conf[taddr[7:2]] + 1) : 0;
    e_sup = m_hv ? (1 << m_hc) : 0;
    @(posedge clk); #1;
    chk(spawn == sg, "R3 spawn_o", int'(spawn), int'(sg));
    chk(int'(src) == e_src && int'(dst) == e_dst, "R4 spawn src*4+dst",
        int'(src) * 4 + int'(dst), e_src * 4 + e_dst);
    chk(kill == kc, "R7 kill_o", int'(kill), int'(kc));
    chk(int'(kcore) == e_kc, "R8 kill_core_o", int'(kcore), e_kc);
    chk(int'(sup) == e_sup, "R9 squash_sup_o", int'(sup), e_sup);
    @(negedge clk);
  endtask

  task automatic idle_in();
    mv = 0; tv = 0; tok = 0; done = '0; exc = '0;
  endtask

  task automatic train(logic [31:0] a, bit ok);
    idle_in(); tv = 1; taddr = a; tok = ok; cyc();
  endtask

  task automatic miss(logic [1:0] c, logic [31:0] a);
    idle_in(); mv = 1; mcore = c; maddr = a; cyc();
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  localparam logic [31:0] ADR_A = 32'h0000_1234;
  localparam logic [31:0] ADR_B = 32'h0000_5678;

  initial begin
    for (int i = 0; i < 64; i++) m_conf[i] = 0;
    rank = {3'd3, 3'd2, 3'd1, 3'd0};
    busy = 4'b0011;
    repeat (3) @(negedge clk);
    chk(spawn == 0 && kill == 0 && sup == 0, "R1 reset outputs", int'(sup), 0);
    rst_n = 1;
    @(negedge clk);
    // R1: untrained table blocks spawn
    miss(2'd1, ADR_A);
    chk(spawn == 0, "R1 untrained miss", int'(spawn), 0);
    // R2: two hits not enough; same-cycle update reads old value
    train(ADR_A, 1); train(ADR_A, 1);
    miss(2'd1, ADR_A);
    chk(spawn == 0, "R2 count 2 not confident", int'(spawn), 0);
    idle_in(); tv = 1; taddr = ADR_A; tok = 1; mv = 1; mcore = 2'd1; maddr = ADR_A; cyc();
    chk(spawn == 0, "R2 lookup before update", int'(spawn), 0);
    // R3: non-most-speculative core cannot spawn
    miss(2'd0, ADR_A);
    chk(spawn == 0, "R3 miss from older thread", int'(spawn), 0);
    // R4: spawn, lowest idle core is 2
    miss(2'd1, ADR_A);
    chk(spawn == 1 && src == 1 && dst == 2, "R4 spawn fields", int'(dst), 2);
    chk(sup == 4'b0100, "R9 suppress on helper", int'(sup), 4);
    // R5: second miss ignored
    miss(2'd1, ADR_A);
    chk(spawn == 0, "R5 no second helper", int'(spawn), 0);
    // R6 + R10: newer thread on core 3 also misses in the same cycle
    idle_in(); busy = 4'b1011; rank[11:9] = 3'd7; mv = 1; mcore = 2'd3; maddr = ADR_A; cyc();
    chk(kill == 1 && kcore == 2 && spawn == 0, "R6 kill on demotion, R10 spawn dropped",
        int'(spawn), 0);
    chk(sup == 0, "R9 suppress clear in kill cycle", int'(sup), 0);
    miss(2'd3, ADR_A);
    chk(spawn == 1 && src == 3 && dst == 2 && kill == 0, "R10 spawn after kill", int'(spawn), 1);
    // R7: helper exception
    idle_in(); exc = 4'b0100; cyc();
    chk(kill == 1 && kcore == 2, "R7 helper exception kill", int'(kill), 1);
    // R2: wrong prediction clears counter
    train(ADR_A, 0);
    miss(2'd3, ADR_A);
    chk(spawn == 0, "R2 cleared counter", int'(spawn), 0);
    train(ADR_B, 1); train(ADR_B, 1); train(ADR_B, 1);
    miss(2'd3, ADR_B);
    chk(spawn == 1 && dst == 2, "R4 respawn", int'(spawn), 1);
    // R7: parent done
    idle_in(); done = 4'b1000; cyc();
    chk(kill == 1, "R7 parent done kill", int'(kill), 1);
    miss(2'd3, ADR_B);
    // R7: helper done
    idle_in(); done = 4'b0100; cyc();
    chk(kill == 1 && kcore == 2, "R7 helper done kill", int'(kill), 1);
    // R3: no idle core
    busy = 4'b1111;
    miss(2'd3, ADR_B);
    chk(spawn == 0, "R3 no idle core", int'(spawn), 0);
    idle_in(); cyc();

    // random phase
    void'($urandom(32'd4242));
    for (int n = 0; n < 6000; n++) begin
      idle_in();
      if ($urandom % 10 == 0) begin busy = 4'($urandom); rank = 12'($urandom); end
      if ($urandom % 30 == 0) done = 4'(1 << ($urandom % 4));
      if ($urandom % 40 == 0) exc  = 4'(1 << ($urandom % 4));
      mv = ($urandom % 2) == 0;
      mcore = 2'($urandom);
      maddr = {24'($urandom), 6'($urandom % 4), 2'b00};
      tv = ($urandom % 5) < 2;
      taddr = {24'($urandom), 6'($urandom % 4), 2'b00};
      tok = ($urandom % 8) != 0;
      cyc();
    end
    summary();
  end
endmodule